// File: doc/BRIEF.md
# Execute-Phase Control Sequencer

This block produces the control strobes that a small register CPU needs during its Execute major cycle. An outer controller raises the execute flag and presents the decoded instruction as one-hot instruction lines. A minor-cycle timer inside the block then steps through four minor cycles, T0 to T3.

In each minor cycle the block asserts a fixed set of signals for the current instruction:
- the register that drives bus B1 and the register that drives bus B2,
- the ALU function, whose result always travels on bus B3,
- the register that latches B3,
- a memory read or write strobe.

Each strobe is the AND of three terms: the execute flag, one minor-cycle flag and one instruction line. After T3 the timer wraps to T0 and raises a done pulse, so that the outer controller can return to instruction fetch. The datapath, the memory, the I/O and the opcode decoder all sit outside this block.

Top module: `exec_ctrl_unit`

## Requirements
- R1: While rst_n is low, asynchronously and held, minorStep is 0. Right after reset, with execFlag low, every strobe output and execDone are 0.
- R2: While execFlag is low, every strobe is 0, whatever the instruction lines. At the clock edge after execFlag was low, minorStep reads 0. This holds even when execFlag drops in the middle of a cycle.
- R3: While execFlag is high, minorStep advances by one per clock from 0 to 3 and then wraps to 0. execDone is 1 exactly when execFlag is high and minorStep is 3.
- R4: The bit positions of the ports are as follows.
  - instrLines: GET=0, PUT=1, RET=2, RTI=3, LDR=4, STR=5, JSR=6, BR=7.
  - b1Sel: IR=0, R=1, SP=2, PC=3, MAR=4.
  - b2Sel: R=0, constant one=1, IOD=2, MBR=3.
  - aluFn: pass B1=0, pass B2=1, add=2, subtract=3.
  - dstLoad: IOA=0, IOD=1, SP=2, MAR=3, MBR=4, PC=5, R=6.
- R5: GET does two transfers and is silent in T1 and T3.
  - T0: IR on B1, pass B1, load IOA.
  - T2: IOD on B2, pass B2, load R.
- R6: PUT does two transfers and is silent in T1 and T3.
  - T0: R on B2, pass B2, load IOD.
  - T2: IR on B1, pass B1, load IOA.
- R7: RET pops the return address and is silent in T2.
  - T0: SP on B1, constant one on B2, add, load SP.
  - T1: SP on B1, pass B1, load MAR, read.
  - T3: MBR on B2, pass B2, load PC.
- R8: LDR is silent in T1 and T3.
  - T0: read only.
  - T2: MBR on B2, pass B2, load R.
- R9: STR acts only in T1: R on B1, pass B1, load MBR, write. It is silent in T0, T2 and T3.
- R10: JSR pushes the return address and acts in all four minor cycles.
  - T0: PC on B1, pass B1, load MBR.
  - T1: MAR on B1, pass B1, load PC.
  - T2: SP on B1, pass B1, load MAR, write.
  - T3: SP on B1, constant one on B2, subtract, load SP.
- R11: BR acts only in T3: MAR on B1, pass B1, load PC. It is silent in T0 to T2.
- R12: RTI, or no instruction line at all, leaves every strobe at 0 in all four minor cycles.
- R13: With at most one instruction line high, each minor cycle has at most one B1 source, at most one B2 source, at most one ALU function and at most one destination load. memRead and memWrite are never high together, and any destination load comes with an ALU function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| execFlag | input | 1 | High while the CPU is in the Execute major cycle |
| instrLines | input | 8 | One-hot decoded instruction, bit positions per R4 |
| minorStep | output | 2 | Current minor cycle, 0 to 3 |
| execDone | output | 1 | High during the last minor cycle of Execute |
| b1Sel | output | 5 | Source register onto bus B1 |
| b2Sel | output | 4 | Source onto bus B2 |
| aluFn | output | 4 | ALU function, result on B3 |
| dstLoad | output | 7 | Register that latches B3 |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |

## Verification
The exclusivity properties assume that the outer decoder never raises more than one instruction line at a time. Without that assumption, two schedules would OR together. The bench keeps to this by only ever applying a single one-hot instruction line or none at all.

The timer properties take execFlag to be a plain level from the outer controller that may drop at any point. The bench therefore drops it both between instructions and in the middle of a cycle, and it holds it high across several wraps.

// File: rtl/exec_ctrl_pkg.sv
package exec_ctrl_pkg;

  localparam int INSTR_COUNT = 8;
  localparam int B1_COUNT    = 5;
  localparam int B2_COUNT    = 4;
  localparam int ALU_COUNT   = 4;
  localparam int DST_COUNT   = 7;
  localparam int SCHED_STEPS = 4;

  // instruction line positions
  localparam int I_GET = 0;
  localparam int I_PUT = 1;
  localparam int I_RET = 2;
  localparam int I_RTI = 3;
  localparam int I_LDR = 4;
  localparam int I_STR = 5;
  localparam int I_JSR = 6;
  localparam int I_BR  = 7;

  // bus B1 sources
  localparam int B1_IR  = 0;
  localparam int B1_R   = 1;
  localparam int B1_SP  = 2;
  localparam int B1_PC  = 3;
  localparam int B1_MAR = 4;

  // bus B2 sources
  localparam int B2_R   = 0;
  localparam int B2_ONE = 1;
  localparam int B2_IOD = 2;
  localparam int B2_MBR = 3;

  // ALU functions
  localparam int FN_PASS1 = 0;
  localparam int FN_PASS2 = 1;
  localparam int FN_ADD   = 2;
  localparam int FN_SUB   = 3;

  // B3 destinations
  localparam int D_IOA = 0;
  localparam int D_IOD = 1;
  localparam int D_SP  = 2;
  localparam int D_MAR = 3;
  localparam int D_MBR = 4;
  localparam int D_PC  = 5;
  localparam int D_R   = 6;

  typedef struct packed {
    logic [B1_COUNT-1:0]  b1;
    logic [B2_COUNT-1:0]  b2;
    logic [ALU_COUNT-1:0] alu;
    logic [DST_COUNT-1:0] dst;
    logic                 rd;
    logic                 wr;
  } strobes_t;

  // Builds a one-bus transfer: source on B1 or B2, matching pass function, load.
  function automatic strobes_t moveVia1(int src, int dst);
    strobes_t s;
    s = '0;
    s.b1[src]       = 1'b1;
    s.alu[FN_PASS1] = 1'b1;
    s.dst[dst]      = 1'b1;
    return s;
  endfunction

  function automatic strobes_t moveVia2(int src, int dst);
    strobes_t s;
    s = '0;
    s.b2[src]       = 1'b1;
    s.alu[FN_PASS2] = 1'b1;
    s.dst[dst]      = 1'b1;
    return s;
  endfunction

  // SP adjusted by the constant one, add or subtract, written back to SP.
  function automatic strobes_t stackStep(int fn);
    strobes_t s;
    s = '0;
    s.b1[B1_SP]  = 1'b1;
    s.b2[B2_ONE] = 1'b1;
    s.alu[fn]    = 1'b1;
    s.dst[D_SP]  = 1'b1;
    return s;
  endfunction

  // Fixed per-instruction schedule over minor cycles 0..3.
  function automatic strobes_t scheduleFor(int instr, int step);
    strobes_t s;
    s = '0;
    case (instr)
      I_GET: begin
        if (step == 0) s = moveVia1(B1_IR, D_IOA);
        if (step == 2) s = moveVia2(B2_IOD, D_R);
      end
      I_PUT: begin
        if (step == 0) s = moveVia2(B2_R, D_IOD);
        if (step == 2) s = moveVia1(B1_IR, D_IOA);
      end
      I_RET: begin
        if (step == 0) s = stackStep(FN_ADD);
        if (step == 1) begin
          s    = moveVia1(B1_SP, D_MAR);
          s.rd = 1'b1;
        end
        if (step == 3) s = moveVia2(B2_MBR, D_PC);
      end
      I_LDR: begin
        if (step == 0) s.rd = 1'b1;
        if (step == 2) s = moveVia2(B2_MBR, D_R);
      end
      I_STR: begin
        if (step == 1) begin
          s    = moveVia1(B1_R, D_MBR);
          s.wr = 1'b1;
        end
      end
      I_JSR: begin
        if (step == 0) s = moveVia1(B1_PC, D_MBR);
        if (step == 1) s = moveVia1(B1_MAR, D_PC);
        if (step == 2) begin
          s    = moveVia1(B1_SP, D_MAR);
          s.wr = 1'b1;
        end
        if (step == 3) s = stackStep(FN_SUB);
      end
      I_BR: begin
        if (step == 3) s = moveVia1(B1_MAR, D_PC);
      end
      default: s = '0;  // RTI and unused lines stay silent
    endcase
    return s;
  endfunction

endpackage

// File: rtl/exec_cycle_timer.sv
module exec_cycle_timer #(
  parameter int MINOR_COUNT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           execFlag,
  output logic [$clog2(MINOR_COUNT)-1:0] minor,
  output logic [MINOR_COUNT-1:0]         stepFlags,
  output logic                           lastStep
);

  localparam int MW = $clog2(MINOR_COUNT);
  localparam logic [MW-1:0] LAST = MW'(MINOR_COUNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minor <= '0;
    end else if (!execFlag) begin
      minor <= '0;
    end else if (minor == LAST) begin
      minor <= '0;
    end else begin
      minor <= minor + 1'b1;
    end
  end

  for (genvar k = 0; k < MINOR_COUNT; k++) begin : g_flag
    assign stepFlags[k] = execFlag && (minor == MW'(k));
  end

  assign lastStep = stepFlags[MINOR_COUNT-1];

endmodule

// File: rtl/exec_signal_decoder.sv
module exec_signal_decoder
  import exec_ctrl_pkg::*;
#(
  parameter int MINOR_COUNT = 4
) (
  input  logic [INSTR_COUNT-1:0] instrLines,
  input  logic [MINOR_COUNT-1:0] stepFlags,
  output strobes_t               strobes
);

  localparam int USED_STEPS = (MINOR_COUNT < SCHED_STEPS) ? MINOR_COUNT : SCHED_STEPS;

  // AND of instruction line and minor-cycle flag selects a schedule term; terms OR together.
  always_comb begin
    strobes_t acc;
    acc = '0;
    for (int i = 0; i < INSTR_COUNT; i++) begin
      for (int k = 0; k < USED_STEPS; k++) begin
        if (instrLines[i] && stepFlags[k]) begin
          acc = strobes_t'(acc | scheduleFor(i, k));
        end
      end
    end
    strobes = acc;
  end

endmodule

// File: rtl/exec_ctrl_unit.sv
module exec_ctrl_unit
  import exec_ctrl_pkg::*;
#(
  parameter int MINOR_COUNT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           execFlag,
  input  logic [INSTR_COUNT-1:0]         instrLines,
  output logic [$clog2(MINOR_COUNT)-1:0] minorStep,
  output logic                           execDone,
  output logic [B1_COUNT-1:0]            b1Sel,
  output logic [B2_COUNT-1:0]            b2Sel,
  output logic [ALU_COUNT-1:0]           aluFn,
  output logic [DST_COUNT-1:0]           dstLoad,
  output logic                           memRead,
  output logic                           memWrite
);

  logic [MINOR_COUNT-1:0] stepFlags;
  strobes_t               strobes;

  exec_cycle_timer #(.MINOR_COUNT(MINOR_COUNT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .execFlag  (execFlag),
    .minor     (minorStep),
    .stepFlags (stepFlags),
    .lastStep  (execDone)
  );

  exec_signal_decoder #(.MINOR_COUNT(MINOR_COUNT)) u_decode (
    .instrLines (instrLines),
    .stepFlags  (stepFlags),
    .strobes    (strobes)
  );

  assign b1Sel    = strobes.b1;
  assign b2Sel    = strobes.b2;
  assign aluFn    = strobes.alu;
  assign dstLoad  = strobes.dst;
  assign memRead  = strobes.rd;
  assign memWrite = strobes.wr;

endmodule

// File: rtl/exec_ctrl_checker.sv
module exec_ctrl_checker
  import exec_ctrl_pkg::*;
#(
  parameter int MINOR_COUNT = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           execFlag,
  input logic [INSTR_COUNT-1:0]         instrLines,
  input logic [$clog2(MINOR_COUNT)-1:0] minorStep,
  input logic                           execDone,
  input logic [B1_COUNT-1:0]            b1Sel,
  input logic [B2_COUNT-1:0]            b2Sel,
  input logic [ALU_COUNT-1:0]           aluFn,
  input logic [DST_COUNT-1:0]           dstLoad,
  input logic                           memRead,
  input logic                           memWrite
);

  localparam int MW = $clog2(MINOR_COUNT);
  localparam logic [MW-1:0] LAST = MW'(MINOR_COUNT - 1);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !execFlag |-> (b1Sel == '0 && b2Sel == '0 && aluFn == '0 && dstLoad == '0
                   && !memRead && !memWrite && !execDone));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !execFlag |=> (minorStep == '0));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (execFlag && minorStep != LAST) |=> (minorStep == MW'($past(minorStep) + 1'b1)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    execDone |=> (minorStep == '0));

  p_str_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(instrLines) && instrLines[I_STR] && minorStep != MW'(1))
      |-> (b1Sel == '0 && dstLoad == '0 && !memWrite));

  p_bus_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(instrLines) |-> ($onehot0(b1Sel) && $onehot0(b2Sel)
                              && $onehot0(aluFn) && $onehot0(dstLoad)));

  p_mem_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(instrLines) |-> !(memRead && memWrite));

  p_load_has_fn_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (dstLoad != '0) |-> (aluFn != '0));

endmodule

bind exec_ctrl_unit exec_ctrl_checker #(.MINOR_COUNT(MINOR_COUNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .execFlag   (execFlag),
  .instrLines (instrLines),
  .minorStep  (minorStep),
  .execDone   (execDone),
  .b1Sel      (b1Sel),
  .b2Sel      (b2Sel),
  .aluFn      (aluFn),
  .dstLoad    (dstLoad),
  .memRead    (memRead),
  .memWrite   (memWrite)
);

// File: tb/exec_ctrl_unit_test.sv
module exec_ctrl_unit_test;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       execFlag;
  logic [7:0] instrLines;
  logic [1:0] minorStep;
  logic       execDone;
  logic [4:0] b1Sel;
  logic [3:0] b2Sel;
  logic [3:0] aluFn;
  logic [6:0] dstLoad;
  logic       memRead;
  logic       memWrite;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  exec_ctrl_unit uut (
    .clk(clk), .rst_n(rst_n), .execFlag(execFlag), .instrLines(instrLines),
    .minorStep(minorStep), .execDone(execDone), .b1Sel(b1Sel), .b2Sel(b2Sel),
    .aluFn(aluFn), .dstLoad(dstLoad), .memRead(memRead), .memWrite(memWrite)
  );

  wire [21:0] outVec = {b1Sel, b2Sel, aluFn, dstLoad, memRead, memWrite};

  // {b1 MAR,PC,SP,R,IR | b2 MBR,IOD,ONE,R | alu sub,add,pass2,pass1 | dst R,PC,MBR,MAR,SP,IOD,IOA | rd | wr}
  localparam logic [21:0] Z = 22'h0;
  localparam logic [21:0] GOLD [0:31] = '{
    // GET (R5)
    {5'b00001, 4'b0000, 4'b0001, 7'b0000001, 1'b0, 1'b0}, Z,
    {5'b00000, 4'b0100, 4'b0010, 7'b1000000, 1'b0, 1'b0}, Z,
    // PUT (R6)
    {5'b00000, 4'b0001, 4'b0010, 7'b0000010, 1'b0, 1'b0}, Z,
    {5'b00001, 4'b0000, 4'b0001, 7'b0000001, 1'b0, 1'b0}, Z,
    // RET (R7)
    {5'b00100, 4'b0010, 4'b0100, 7'b0000100, 1'b0, 1'b0},
    {5'b00100, 4'b0000, 4'b0001, 7'b0001000, 1'b1, 1'b0}, Z,
    {5'b00000, 4'b1000, 4'b0010, 7'b0100000, 1'b0, 1'b0},
    // RTI (R12)
    Z, Z, Z, Z,
    // LDR (R8)
    {5'b00000, 4'b0000, 4'b0000, 7'b0000000, 1'b1, 1'b0}, Z,
    {5'b00000, 4'b1000, 4'b0010, 7'b1000000, 1'b0, 1'b0}, Z,
    // STR (R9)
    Z, {5'b00010, 4'b0000, 4'b0001, 7'b0010000, 1'b0, 1'b1}, Z, Z,
    // JSR (R10)
    {5'b01000, 4'b0000, 4'b0001, 7'b0010000, 1'b0, 1'b0},
    {5'b10000, 4'b0000, 4'b0001, 7'b0100000, 1'b0, 1'b0},
    {5'b00100, 4'b0000, 4'b0001, 7'b0001000, 1'b0, 1'b1},
    {5'b00100, 4'b0010, 4'b1000, 7'b0000100, 1'b0, 1'b0},
    // BR (R11)
    Z, Z, Z, {5'b10000, 4'b0000, 4'b0001, 7'b0100000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(int i);
    case (i)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R12";
      4: return "R8";
      5: return "R9";
      6: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Runs one full Execute cycle from T0 and compares every minor cycle with GOLD.
  task automatic runInstr(input int idx);
    @(negedge clk);
    execFlag = 1'b0;
    @(negedge clk);
    instrLines = 8'(1 << idx);
    execFlag   = 1'b1;
    for (int t = 0; t < 4; t++) begin
      #1;
      check({reqOf(idx), " R4"}, $sformatf("instr%0d T%0d strobes", idx, t),
            32'(outVec), 32'(GOLD[idx*4 + t]));
      check("R3", "minorStep", 32'(minorStep), 32'(t));
      check("R3", "execDone", 32'(execDone), 32'(t == 3));
      check("R13", "one-hot0 per group",
            32'($onehot0(b1Sel) && $onehot0(b2Sel) && $onehot0(aluFn)
                && $onehot0(dstLoad) && !(memRead && memWrite)), 32'(1));
      @(negedge clk);
    end
    #1;
    check("R3", "wrap to T0", 32'(minorStep), 32'(0));
    execFlag = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    execFlag = 1'b0;
    instrLines = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "minor in reset", 32'(minorStep), 32'(0));
    check("R1", "strobes in reset", 32'(outVec), 32'(0));
    check("R1", "done in reset", 32'(execDone), 32'(0));
    // Reset holds the timer even with execFlag high
    execFlag = 1'b1;
    instrLines = 8'h40;
    repeat (2) @(negedge clk);
    #1;
    check("R1", "minor held by reset", 32'(minorStep), 32'(0));
    execFlag = 1'b0;
    rst_n = 1'b1;

    // R2: outside Execute nothing fires and the timer stays at 0
    instrLines = 8'h01;
    repeat (3) @(negedge clk);
    #1;
    check("R2", "strobes idle", 32'(outVec), 32'(0));
    check("R2", "minor idle", 32'(minorStep), 32'(0));
    check("R2", "done idle", 32'(execDone), 32'(0));

    // Table walk over all eight instruction lines
    for (int i = 0; i < 8; i++) runInstr(i);

    // R12: no instruction line at all
    @(negedge clk);
    instrLines = 8'h00;
    execFlag = 1'b1;
    for (int t = 0; t < 4; t++) begin
      #1;
      check("R12", $sformatf("no line T%0d", t), 32'(outVec), 32'(0));
      @(negedge clk);
    end
    execFlag = 1'b0;

    // R2: drop execFlag in the middle of JSR
    @(negedge clk);
    instrLines = 8'h40;
    execFlag = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R3", "mid JSR minor", 32'(minorStep), 32'(2));
    execFlag = 1'b0;
    #1;
    check("R2", "drop mid-cycle strobes", 32'(outVec), 32'(0));
    @(negedge clk);
    #1;
    check("R2", "drop mid-cycle minor", 32'(minorStep), 32'(0));

    // R3: back-to-back BR cycles with execFlag held high
    instrLines = 8'h80;
    execFlag = 1'b1;
    for (int t = 0; t < 8; t++) begin
      #1;
      check("R3", $sformatf("held minor c%0d", t), 32'(minorStep), 32'(t % 4));
      check("R11", $sformatf("held BR c%0d", t), 32'(outVec),
            32'((t % 4 == 3) ? GOLD[31] : Z));
      check("R3", $sformatf("held done c%0d", t), 32'(execDone), 32'(t % 4 == 3));
      @(negedge clk);
    end

    // R1: asynchronous reset during Execute
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R1", "async reset minor", 32'(minorStep), 32'(0));
    execFlag = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule